// File: doc/BRIEF.md
# FM Operator Envelope Generator

This block produces the 10-bit attenuation envelope of one operator in an FM synthesis voice. It runs the four phases (attack, decay, sustain, release) and moves between them on key events and level thresholds. The amount of change per step comes from an effective rate: the programmed rate, mapped onto a 0..127 scale, plus a key-scale offset. An attenuation of 0 is loudest and 1023 is silent.

A counter shared by all operators, together with a one-cycle tick strobe, decides when a phase may move. The effective rate picks a shift. The operator updates only on ticks where the counter's low `shift` bits are zero. Three counter bits above the shift then index an eight-step increment pattern, and the rate picks which pattern. A repeating-envelope mode bit scales the decay and release steps by six. The sustain step is always scaled by six. In repeating mode the sustain phase also restarts the envelope once the attenuation passes half scale.

The block has no streaming data path. Every input is a plain level or strobe sampled on each clock. The only output is the registered attenuation and phase, which is valid in every cycle. There is no back-pressure, and the tick strobe is a qualifier rather than a handshake.

Top module: `eg_env_gen`

## Requirements
- R1: While `rst_n` is low, `atten` is 1023 and `phase` is release. The phase codes are 0 attack, 1 decay, 2 sustain and 3 release.
- R2: A `key_on` cycle whose attack index is below 94 sets the phase to attack and leaves `atten` unchanged. The attack index is the mapped attack rate plus `key_scale`. `key_on` wins over `key_off` and over every phase action.
- R3: A `key_on` cycle whose attack index is 94 or more sets `atten` to 0 and the phase to decay.
- R4: A `key_off` cycle without `key_on` sets the phase to release from any phase and leaves `atten` unchanged.
- R5: Rate mapping works as follows. A 5-bit attack, decay or sustain rate value v maps to 0 when v is 0, and to 32+2v otherwise. A 4-bit release value v maps to 34+4v. `key_scale` is added to the mapped value to form the index. An index below 34 never changes the attenuation.
- R6: A phase steps only on a cycle with `eg_tick` high where `eg_cnt` mod 2^shift is 0. For an index i of 32 or more, the rate group is r=(i-32)>>2 and the shift is 11-r when r is 11 or less, and 0 otherwise.
- R7: The increment is pattern entry j=(eg_cnt>>shift)&7, with s=i&3. Pattern selection: rate group 0 uses pattern 0 when s is 2 or 3. Rate group 1 uses pattern 0 for s of 0 or 1, and pattern 2 for s of 2 or 3. Rate groups 2..11 use pattern s. Rate groups 12..14 use pattern 4(r-11)+s. Rate group 15 and above use a constant step of 8. Pattern p, with l=p>>2 and t=p&3, uses the values hi=2^l and lo (0 if l=0, else 2^(l-1)). For l=0, hi appears at odd j when t=0, at odd j and j=4 when t=1, at j not 0 or 4 when t=2, and at j not 0 when t=3. For l>0, hi appears nowhere when t=0, at j 3 and 7 when t=1, at odd j when t=2, and at j not 0 or 4 when t=3.
- R8: An attack step lowers `atten` by ceil((atten+1)*inc/16). A step that would reach or pass 0 sets `atten` to 0 and the phase to decay.
- R9: A decay step adds inc, or 6*inc when `loop_mode[3]` is set. In every decay cycle, ticked or not, the resulting level is compared with the sustain level, which is 992 for `sus_lvl`=15 and 32*`sus_lvl` otherwise. If the level is at or above it, `atten` is clamped to the sustain level and the phase becomes sustain.
- R10: A sustain step adds 6*inc, saturating at 1023. With `loop_mode[3]` set, a step whose result is 512 or more restarts the envelope. If the attack index is 94 or more, `atten` becomes 0, and the phase becomes sustain when `sus_lvl` is 0 and decay otherwise. If not, the result is kept and the phase becomes attack.
- R11: A release step adds inc, or 6*inc when `loop_mode[3]` is set, saturating at 1023 and holding there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_on | input | 1 | One-cycle key-on strobe |
| key_off | input | 1 | One-cycle key-off strobe |
| eg_tick | input | 1 | Envelope tick qualifier |
| eg_cnt | input | CNT_W | Shared envelope counter value |
| atk_rate | input | 5 | Attack rate value |
| dec_rate | input | 5 | Decay rate value |
| sus_rate | input | 5 | Sustain-phase rate value |
| rel_rate | input | 4 | Release rate value |
| sus_lvl | input | 4 | Sustain level value |
| key_scale | input | 5 | Key-scale rate offset |
| loop_mode | input | 4 | Repeating-envelope field, bit 3 enables it |
| atten | output | 10 | Current attenuation |
| phase | output | 2 | Current phase code |

## Verification
Each transition's effect is visible at the ports one clock after the cycle that caused it. A wrong phase register shows up as a wrong `phase` code, and as the wrong rate driving `atten` on the next ticks. A wrong shift or pattern selection shows up as a step landing on the wrong counter value, or with the wrong size, at the first tick where that rate is used. A missed decay-to-sustain clamp shows up as `atten` passing the sustain level in the cycle after the crossing. Key-on decisions are swept over every attack value against every key-scale offset. Long randomized envelopes are compared cycle by cycle with an arithmetic model built from the requirements.

// File: rtl/eg_pkg.sv
package eg_pkg;
  localparam int ATT_W = 10;
  localparam int IDX_W = 7;
  localparam int INC_W = 4;
  localparam int GRP_W = 5;
  localparam int SHF_W = 4;

  localparam logic [ATT_W-1:0] ATT_MAX    = '1;
  localparam logic [ATT_W-1:0] LOOP_LVL   = ATT_W'(512);
  localparam logic [IDX_W-1:0] BYPASS_IDX = IDX_W'(94);
  localparam logic [GRP_W-1:0] GRP_FLAT   = GRP_W'(16);
  localparam logic [GRP_W-1:0] GRP_ZERO   = GRP_W'(18);

  typedef enum logic [1:0] {
    PH_ATTACK  = 2'd0,
    PH_DECAY   = 2'd1,
    PH_SUSTAIN = 2'd2,
    PH_RELEASE = 2'd3
  } eg_phase_t;

  // 5-bit rate value onto the 0..127 index scale
  function automatic logic [IDX_W-1:0] map_rate5(input logic [4:0] v);
    return (v == 5'd0) ? '0 : IDX_W'(32) + {1'b0, v, 1'b0};
  endfunction

  // 4-bit release value onto the index scale
  function automatic logic [IDX_W-1:0] map_rel4(input logic [3:0] v);
    return IDX_W'(34) + {1'b0, v, 2'b00};
  endfunction
endpackage

// File: rtl/eg_rate_map.sv
module eg_rate_map
  import eg_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output logic [SHF_W-1:0] shift,
  output logic [GRP_W-1:0] group
);
  logic [IDX_W-1:0] above;
  logic [4:0]       rate;
  logic [1:0]       sub;

  always_comb begin
    above = idx - IDX_W'(32);
    rate  = 5'(above >> 2);
    sub   = idx[1:0];
    shift = '0;
    group = GRP_ZERO;
    if (idx >= IDX_W'(32)) begin
      shift = (rate <= 5'd11) ? SHF_W'(5'd11 - rate) : '0;
      if (rate == 5'd0)       group = sub[1] ? GRP_W'(0) : GRP_ZERO;
      else if (rate == 5'd1)  group = sub[1] ? GRP_W'(2) : GRP_W'(0);
      else if (rate <= 5'd11) group = {3'b000, sub};
      else if (rate <= 5'd14) group = {rate[2:0] - 3'd3, sub};
      else                    group = GRP_FLAT;
    end
  end
endmodule

// File: rtl/eg_inc_pick.sv
module eg_inc_pick
  import eg_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic [GRP_W-1:0] group,
  input  logic [SHF_W-1:0] shift,
  input  logic [CNT_W-1:0] cnt,
  input  logic             tick,
  output logic             fire,
  output logic [INC_W-1:0] inc
);
  logic [CNT_W-1:0] low_mask;
  logic [2:0]       sel;
  logic [1:0]       lvl;
  logic [1:0]       sub;
  logic [INC_W-1:0] hi;
  logic [INC_W-1:0] lo;
  logic             use_hi;

  always_comb begin
    low_mask = (CNT_W'(1) << shift) - CNT_W'(1);
    sel      = 3'(cnt >> shift);
    lvl      = group[3:2];
    sub      = group[1:0];
    hi       = INC_W'(1) << lvl;
    lo       = (lvl == 2'd0) ? '0 : INC_W'(1) << (lvl - 2'd1);
    if (lvl == 2'd0) begin
      unique case (sub)
        2'd0:    use_hi = sel[0];
        2'd1:    use_hi = sel[0] | (sel == 3'd4);
        2'd2:    use_hi = (sel[1:0] != 2'd0);
        default: use_hi = (sel != 3'd0);
      endcase
    end else begin
      unique case (sub)
        2'd0:    use_hi = 1'b0;
        2'd1:    use_hi = (sel[1:0] == 2'd3);
        2'd2:    use_hi = sel[0];
        default: use_hi = (sel[1:0] != 2'd0);
      endcase
    end
    if (group == GRP_FLAT)     inc = INC_W'(8);
    else if (group > GRP_W'(15)) inc = '0;
    else                       inc = use_hi ? hi : lo;
    fire = tick && ((cnt & low_mask) == '0) && (inc != '0);
  end
endmodule

// File: rtl/eg_env_gen.sv
module eg_env_gen
  import eg_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_on,
  input  logic             key_off,
  input  logic             eg_tick,
  input  logic [CNT_W-1:0] eg_cnt,
  input  logic [4:0]       atk_rate,
  input  logic [4:0]       dec_rate,
  input  logic [4:0]       sus_rate,
  input  logic [3:0]       rel_rate,
  input  logic [3:0]       sus_lvl,
  input  logic [4:0]       key_scale,
  input  logic [3:0]       loop_mode,
  output logic [9:0]       atten,
  output logic [1:0]       phase
);
  localparam int NPH  = 4;
  localparam int SUMW = ATT_W + 1;
  localparam int PRW  = SUMW + INC_W;
  localparam int ADDW = INC_W + 2;

  eg_phase_t        ph_q, ph_n;
  logic [ATT_W-1:0] att_q, att_n;

  logic [IDX_W-1:0] idx_arr [NPH];
  logic [SHF_W-1:0] shf_arr [NPH];
  logic [GRP_W-1:0] grp_arr [NPH];

  // effective index per phase: mapped rate plus key-scale offset
  always_comb begin
    idx_arr[0] = map_rate5(atk_rate) + IDX_W'(key_scale);
    idx_arr[1] = map_rate5(dec_rate) + IDX_W'(key_scale);
    idx_arr[2] = map_rate5(sus_rate) + IDX_W'(key_scale);
    idx_arr[3] = map_rel4(rel_rate)  + IDX_W'(key_scale);
  end

  generate
    for (genvar p = 0; p < NPH; p++) begin : g_map
      eg_rate_map u_map (
        .idx   (idx_arr[p]),
        .shift (shf_arr[p]),
        .group (grp_arr[p])
      );
    end
  endgenerate

  logic [1:0]       ph_sel;
  logic             fire;
  logic [INC_W-1:0] inc;

  assign ph_sel = 2'(ph_q);

  eg_inc_pick #(.CNT_W(CNT_W)) u_pick (
    .group (grp_arr[ph_sel]),
    .shift (shf_arr[ph_sel]),
    .cnt   (eg_cnt),
    .tick  (eg_tick),
    .fire  (fire),
    .inc   (inc)
  );

  logic             bypass;
  logic             loop_on;
  logic [ATT_W-1:0] sl_att;
  logic [ADDW-1:0]  inc6;
  logic [ADDW-1:0]  add_amt;
  logic [SUMW-1:0]  sum;
  logic [ATT_W-1:0] sat;
  logic [PRW-1:0]   prod;
  logic [SUMW-1:0]  drop;

  always_comb begin
    bypass  = (idx_arr[0] >= BYPASS_IDX);
    loop_on = loop_mode[3];
    sl_att  = (sus_lvl == 4'hF) ? {5'h1F, 5'h00} : {1'b0, sus_lvl, 5'h00};
    inc6    = ({2'b00, inc} << 2) + ({2'b00, inc} << 1);
    add_amt = ((ph_q == PH_SUSTAIN) || loop_on) ? inc6 : {2'b00, inc};
    sum     = {1'b0, att_q} + SUMW'(fire ? add_amt : '0);
    sat     = sum[ATT_W] ? ATT_MAX : sum[ATT_W-1:0];
    prod    = PRW'({1'b0, att_q} + SUMW'(1)) * PRW'(inc);
    drop    = SUMW'((prod + PRW'(15)) >> 4);
  end

  always_comb begin
    ph_n  = ph_q;
    att_n = att_q;
    if (key_on) begin
      if (bypass) begin
        att_n = '0;
        ph_n  = PH_DECAY;
      end else begin
        ph_n  = PH_ATTACK;
      end
    end else if (key_off) begin
      ph_n = PH_RELEASE;
    end else begin
      unique case (ph_q)
        PH_ATTACK: begin
          if (fire) begin
            if (drop >= {1'b0, att_q}) begin
              att_n = '0;
              ph_n  = PH_DECAY;
            end else begin
              att_n = att_q - drop[ATT_W-1:0];
            end
          end
        end
        PH_DECAY: begin
          if (sat >= sl_att) begin
            att_n = sl_att;
            ph_n  = PH_SUSTAIN;
          end else begin
            att_n = sat;
          end
        end
        PH_SUSTAIN: begin
          if (fire) begin
            if (loop_on && (sat >= LOOP_LVL)) begin
              if (bypass) begin
                att_n = '0;
                ph_n  = (sus_lvl == 4'd0) ? PH_SUSTAIN : PH_DECAY;
              end else begin
                att_n = sat;
                ph_n  = PH_ATTACK;
              end
            end else begin
              att_n = sat;
            end
          end
        end
        default: begin
          if (fire) att_n = sat;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_RELEASE;
      att_q <= ATT_MAX;
    end else begin
      ph_q  <= ph_n;
      att_q <= att_n;
    end
  end

  assign atten = att_q;
  assign phase = ph_sel;

  AST_KEYON_ATTACK: assert property (@(posedge clk) disable iff (!rst_n)
    key_on && !bypass |=> ph_q == PH_ATTACK && $stable(att_q)); // R2
  AST_KEYON_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    key_on && bypass |=> ph_q == PH_DECAY && att_q == '0); // R3
  AST_KEYOFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    key_off && !key_on |=> ph_q == PH_RELEASE && $stable(att_q)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !eg_tick && !key_on && !key_off && ph_q != PH_DECAY |=> $stable(att_q)); // R6
  AST_ATTACK_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_ATTACK && !key_on && !key_off |=> att_q <= $past(att_q)); // R8
  AST_DECAY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_DECAY && !key_on && !key_off |=>
      (ph_q == PH_SUSTAIN && att_q == $past(sl_att)) ||
      (ph_q == PH_DECAY && att_q < $past(sl_att))); // R9
  AST_RELEASE_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_RELEASE && !key_on |=> att_q >= $past(att_q)); // R11
endmodule

// File: tb/eg_env_gen_bench.sv
module eg_env_gen_bench;
  localparam int CW = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          key_on = 1'b0, key_off = 1'b0, eg_tick = 1'b0;
  logic [CW-1:0] eg_cnt = '0;
  logic [4:0]    atk_rate = '0, dec_rate = '0, sus_rate = '0, key_scale = '0;
  logic [3:0]    rel_rate = '0, sus_lvl = '0, loop_mode = '0;
  logic [9:0]    atten;
  logic [1:0]    phase;

  always #4 clk = ~clk;

  eg_env_gen #(.CNT_W(CW)) u_eg_env_gen (
    .clk(clk), .rst_n(rst_n), .key_on(key_on), .key_off(key_off),
    .eg_tick(eg_tick), .eg_cnt(eg_cnt), .atk_rate(atk_rate),
    .dec_rate(dec_rate), .sus_rate(sus_rate), .rel_rate(rel_rate),
    .sus_lvl(sus_lvl), .key_scale(key_scale), .loop_mode(loop_mode),
    .atten(atten), .phase(phase)
  );

  int    n_chk = 0, n_bad = 0;
  int    m_att = 1023, m_ph = 3;
  string tag_force = "";
  bit    auto_cnt = 1'b0;
  bit    done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int eff5(int v);
    return (v == 0) ? 0 : 32 + 2 * v;
  endfunction

  function automatic int effr(int v);
    return 34 + 4 * v;
  endfunction

  function automatic int b_shift(int idx);
    int r;
    if (idx < 32) return 0;
    r = (idx - 32) / 4;
    return (r <= 11) ? 11 - r : 0;
  endfunction

  function automatic int b_group(int idx);
    int r, s;
    if (idx < 34) return 18;
    r = (idx - 32) / 4;
    s = idx % 4;
    if (r == 0) return 0;
    if (r == 1) return (s < 2) ? 0 : 2;
    if (r <= 11) return s;
    if (r <= 14) return (r - 11) * 4 + s;
    return 16;
  endfunction

  function automatic int b_inc(int idx, int j);
    int g, l, t, hi, lo;
    logic [7:0] msk;
    g = b_group(idx);
    if (g == 18) return 0;
    if (g == 16) return 8;
    l = g / 4; t = g % 4;
    hi = 1 << l;
    lo = (l == 0) ? 0 : (1 << (l - 1));
    if (l == 0) msk = (t == 0) ? 8'hAA : (t == 1) ? 8'hBA : (t == 2) ? 8'hEE : 8'hFE;
    else        msk = (t == 0) ? 8'h00 : (t == 1) ? 8'h88 : (t == 2) ? 8'hAA : 8'hEE;
    return msk[j] ? hi : lo;
  endfunction

  function automatic string ph_tag(int ph);
    case (ph)
      0: return "R8";
      1: return "R9";
      2: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string tag, int got, int exp, string what);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // next expected state from the driven inputs, per the requirements
  task automatic m_step();
    int ia, idx, sh, inc, d, a, mul, slv, cv;
    bit byp, go, rep;
    ia  = eff5(int'(atk_rate)) + int'(key_scale);
    byp = (ia >= 94);
    rep = loop_mode[3];
    slv = (sus_lvl == 4'hF) ? 992 : 32 * int'(sus_lvl);
    cv  = int'(eg_cnt);
    if (key_on) begin
      if (byp) begin m_att = 0; m_ph = 1; end
      else m_ph = 0;
    end else if (key_off) begin
      m_ph = 3;
    end else begin
      case (m_ph)
        0: idx = ia;
        1: idx = eff5(int'(dec_rate)) + int'(key_scale);
        2: idx = eff5(int'(sus_rate)) + int'(key_scale);
        default: idx = effr(int'(rel_rate)) + int'(key_scale);
      endcase
      sh  = b_shift(idx);
      inc = b_inc(idx, (cv >> sh) % 8);
      go  = eg_tick && ((cv % (1 << sh)) == 0) && (inc > 0);
      mul = rep ? 6 : 1;
      case (m_ph)
        0: if (go) begin
          d = ((m_att + 1) * inc + 15) / 16;
          if (d >= m_att) begin m_att = 0; m_ph = 1; end
          else m_att = m_att - d;
        end
        1: begin
          a = m_att + (go ? inc * mul : 0);
          if (a > 1023) a = 1023;
          if (a >= slv) begin m_att = slv; m_ph = 2; end
          else m_att = a;
        end
        2: if (go) begin
          a = m_att + 6 * inc;
          if (a > 1023) a = 1023;
          if (rep && a >= 512) begin
            if (byp) begin m_att = 0; m_ph = (sus_lvl == 0) ? 2 : 1; end
            else begin m_att = a; m_ph = 0; end
          end else m_att = a;
        end
        default: if (go) begin
          a = m_att + inc * mul;
          m_att = (a > 1023) ? 1023 : a;
        end
      endcase
    end
  endtask

  task automatic step();
    string tg;
    m_step();
    @(posedge clk);
    @(negedge clk);
    tg = (tag_force != "") ? tag_force : ph_tag(m_ph);
    chk(tg, int'(atten), m_att, "attenuation");
    chk(tg, int'(phase), m_ph, "phase");
    if (auto_cnt && eg_tick) eg_cnt = eg_cnt + 1'b1;
  endtask

  task automatic rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(atten), 1023, "reset attenuation");
    chk("R1", int'(phase), 3, "reset phase");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(atten), 1023, "attenuation after reset");

    // R2/R3/R4: every attack value against every key-scale offset
    eg_tick = 1'b0;
    for (int ar = 0; ar < 32; ar++) begin
      for (int ks = 0; ks < 32; ks++) begin
        atk_rate = 5'(ar); key_scale = 5'(ks);
        key_on = 1'b1;
        tag_force = (eff5(ar) + ks >= 94) ? "R3" : "R2";
        step();
        key_on = 1'b0; key_off = 1'b1; tag_force = "R4";
        step();
        key_off = 1'b0;
      end
    end

    // R7: constant step of 8 in release from zero
    atk_rate = 5'd31; key_scale = 5'd0; dec_rate = 5'd0; sus_lvl = 4'hF;
    loop_mode = 4'd0; rel_rate = 4'hF; eg_tick = 1'b1; auto_cnt = 1'b1;
    key_on = 1'b1; tag_force = "R3"; step(); key_on = 1'b0;
    key_off = 1'b1; tag_force = "R4"; step(); key_off = 1'b0;
    tag_force = "R7";
    for (int k = 1; k <= 140; k++) begin
      step();
      chk("R7", int'(atten), (8 * k > 1023) ? 1023 : 8 * k, "release ramp");
    end

    // R5: zero attack rate never moves
    atk_rate = 5'd0; key_on = 1'b1; tag_force = "R5"; step(); key_on = 1'b0;
    for (int k = 0; k < 40; k++) step();
    chk("R5", int'(atten), 1023, "held attenuation");

    // R6: slowest attack waits for an aligned counter
    atk_rate = 5'd1; auto_cnt = 1'b0; eg_cnt = 15'd1;
    key_on = 1'b1; tag_force = "R6"; step(); key_on = 1'b0;
    for (int k = 0; k < 60; k++) step();
    chk("R6", int'(atten), 1023, "unaligned counter");
    eg_cnt = 15'd2048; step();
    chk("R6", int'(atten), 959, "aligned attack step");
    eg_cnt = 15'd4096; tag_force = "R7"; step();
    chk("R7", int'(atten), 959, "zero pattern entry");

    // R11: repeating mode scales release by six
    atk_rate = 5'd31; auto_cnt = 1'b1;
    key_on = 1'b1; tag_force = "R3"; step(); key_on = 1'b0;
    key_off = 1'b1; tag_force = "R4"; step(); key_off = 1'b0;
    loop_mode = 4'b1000; tag_force = "R11";
    for (int k = 1; k <= 25; k++) begin
      step();
      chk("R11", int'(atten), (48 * k > 1023) ? 1023 : 48 * k, "scaled release");
    end

    // R10: sustain loop restart with bypassed attack
    sus_lvl = 4'd0; sus_rate = 5'd31;
    key_on = 1'b1; tag_force = "R3"; step(); key_on = 1'b0;
    tag_force = "R10";
    for (int k = 0; k < 40; k++) step();
    sus_lvl = 4'd3; sus_rate = 5'd30; atk_rate = 5'd20; dec_rate = 5'd31;
    key_on = 1'b1; step(); key_on = 1'b0;
    for (int k = 0; k < 400; k++) step();

    // randomized envelopes against the model
    tag_force = "";
    for (int e = 0; e < 70; e++) begin
      rnd(); atk_rate = 5'(14 + int'(lfsr[7:0]) % 18);
      rnd(); dec_rate = 5'(16 + int'(lfsr[3:0]));
      rnd(); sus_rate = lfsr[4:0];
      rnd(); rel_rate = lfsr[3:0];
      rnd(); sus_lvl  = lfsr[3:0];
      rnd(); key_scale = lfsr[4:0];
      rnd(); loop_mode = lfsr[3:0];
      key_on = 1'b1; eg_tick = 1'b1; step(); key_on = 1'b0;
      for (int k = 0; k < 700; k++) begin
        rnd(); eg_tick = (lfsr[1:0] != 2'b00);
        step();
      end
      key_off = 1'b1; step(); key_off = 1'b0;
      for (int k = 0; k < 300; k++) begin
        rnd(); eg_tick = (lfsr[1:0] != 2'b00);
        step();
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule